// File: doc/BRIEF.md
# Prefix-Extended Stack-Relative Load Unit

This unit carries out a load whose address is the stack pointer plus an immediate displacement. It reads one 32-bit word from a synchronous data memory and writes the low 24 bits of that word into one of eight general registers. The load itself supplies a 7-bit displacement field. Up to two immediate-extension prefix instructions placed just before the load widen that displacement to 20 or 24 bits. A load that sits in a branch delay slot uses only its own 7-bit field. An address that is not word aligned raises a misalignment interrupt request. The read still goes ahead, at the address with its two low bits cleared.

The unit receives a decoded instruction stream, one instruction per cycle. The 2-bit code `op_kind` is idle=0, prefix=1, load=2 or any other instruction=3. A prefix carries its immediate in `op_imm[12:0]`. A load carries its displacement in `op_imm[6:0]`, its destination in `op_rd` and its delay-slot flag in `op_slot`. The memory returns read data on the cycle after the read strobe.

Top module: `lda_unit`

## Requirements
- R1: A load with no pending prefix reads at address SP + imm7 (imm7 = `op_imm[6:0]`, zero-extended).
- R2: With one pending prefix of immediate P (13 bits), the displacement is {4'b0, P, imm7}. An idle cycle (`op_kind`=0) between the prefix and the load keeps the prefix pending.
- R3: With two pending prefixes, the first one's `op_imm[3:0]` forms displacement bits 23:20, the second one's 13 bits form bits 19:7, and imm7 forms bits 6:0.
- R4: The register write value is bits 23:0 of the word returned by memory. Bits 31:24 are discarded.
- R5: The register write index equals the `op_rd` (0 to 7) of the load that produced it.
- R6: When bits 1:0 of the effective address are nonzero, `misalign_irq` is high for exactly the cycle in which `mem_rd_en` is high. `mem_addr` always has bits 1:0 equal to zero.
- R7: A load with `op_slot`=1 ignores any pending prefixes and uses the 7-bit displacement alone.
- R8: A load sampled at clock edge E drives `mem_rd_en` for one cycle after E. It then drives `rf_we` for one cycle after E+1, so the load takes two cycles.
- R9: Address arithmetic wraps modulo 2^24.
- R10: Pending prefixes are cleared by any load or other instruction (`op_kind` 2 or 3) and by reset.
- R11: A third consecutive prefix drops the oldest, so the last two prefixes are the ones applied.
- R12: While in reset and right after it, `mem_rd_en`, `rf_we` and `misalign_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | Instruction class: 0 idle, 1 prefix, 2 load, 3 other |
| op_imm | input | 13 | Prefix immediate, or load displacement in bits 6:0 |
| op_rd | input | 3 | Load destination register index |
| op_slot | input | 1 | Load is in a branch delay slot |
| sp | input | 24 | Current stack pointer |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 3 | Register write index |
| rf_wdata | output | 24 | Register write value |
| misalign_irq | output | 1 | Misaligned-address interrupt request pulse |

## Verification
Loads are applied with zero, one, two and three prefixes. This separates the three displacement layouts and confirms that a third prefix displaces the oldest. A delay-slot load with a prefix pending shows that the prefix is ignored. Stack pointer values near the top of the address space show the 24-bit wrap. Aligned and misaligned sums set apart the interrupt pulse from the forced-alignment read. Other-instruction, idle and reset cycles placed between a prefix and its load show when a prefix survives and when it is dropped.

// File: rtl/lda_pkg.sv
package lda_pkg;

    localparam int ADDR_W   = 24;
    localparam int WORD_W   = 32;
    localparam int REG_W    = 24;
    localparam int IDX_W    = 3;
    localparam int LOW_W    = 7;
    localparam int MID_W    = 13;
    localparam int TOP_W    = 4;
    localparam int ALIGN_W  = 2;

    typedef enum logic [1:0] {
        OPK_IDLE  = 2'd0,
        OPK_PFX   = 2'd1,
        OPK_LOAD  = 2'd2,
        OPK_OTHER = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic [1:0]       depth;
        logic [TOP_W-1:0] top_part;
        logic [MID_W-1:0] mid_part;
    } pfx_acc_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              irq;
        logic [IDX_W-1:0]  idx;
    } rd_req_t;

    function automatic logic [ADDR_W-1:0] build_disp(
        input pfx_acc_t         acc,
        input logic             in_slot,
        input logic [LOW_W-1:0] low
    );
        logic [ADDR_W-1:0] d;
        d = '0;
        d[LOW_W-1:0] = low;
        if (!in_slot && acc.depth != 2'd0)
            d[LOW_W+MID_W-1:LOW_W] = acc.mid_part;
        if (!in_slot && acc.depth == 2'd2)
            d[ADDR_W-1:LOW_W+MID_W] = acc.top_part;
        return d;
    endfunction

endpackage

// File: rtl/lda_prefix_acc.sv
module lda_prefix_acc
    import lda_pkg::*;
#(
    parameter int IMM_W = MID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  op_kind_e         kind,
    input  logic [IMM_W-1:0] imm,
    output pfx_acc_t         acc
);

    pfx_acc_t nxt;

    always_comb begin
        nxt = acc;
        unique case (kind)
            OPK_PFX: begin
                nxt.top_part = acc.mid_part[TOP_W-1:0];
                nxt.mid_part = imm;
                nxt.depth    = (acc.depth == 2'd2) ? 2'd2 : acc.depth + 2'd1;
            end
            OPK_LOAD, OPK_OTHER: nxt = '0;
            default: nxt = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= nxt;
    end

endmodule

// File: rtl/lda_addr_gen.sv
module lda_addr_gen
    import lda_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int AL = ALIGN_W
) (
    input  pfx_acc_t         acc,
    input  logic             in_slot,
    input  logic [LOW_W-1:0] low,
    input  logic [AW-1:0]    base,
    output logic [AW-1:0]    word_addr,
    output logic             misaligned
);

    logic [AW-1:0] disp;
    logic [AW-1:0] eff;

    always_comb begin
        disp       = build_disp(acc, in_slot, low);
        eff        = base + disp;
        word_addr  = {eff[AW-1:AL], {AL{1'b0}}};
        misaligned = |eff[AL-1:0];
    end

endmodule

// File: rtl/lda_access_seq.sv
module lda_access_seq
    import lda_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int RW = REG_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [AW-1:0] addr,
    input  logic          bad_align,
    input  logic [IW-1:0] dest,
    input  logic [DW-1:0] rdata,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          irq,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [RW-1:0] wr_data
);

    rd_req_t       req_q;
    logic          wb_vld_q;
    logic [IW-1:0] wb_idx_q;
    logic [DW-RW-1:0] unused_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            wb_vld_q <= 1'b0;
            wb_idx_q <= '0;
        end else begin
            req_q.vld  <= issue;
            req_q.addr <= addr;
            req_q.irq  <= issue & bad_align;
            req_q.idx  <= dest;
            wb_vld_q   <= req_q.vld;
            wb_idx_q   <= req_q.idx;
        end
    end

    always_comb begin
        rd_en     = req_q.vld;
        rd_addr   = req_q.addr;
        irq       = req_q.irq;
        wr_en     = wb_vld_q;
        wr_idx    = wb_idx_q;
        wr_data   = rdata[RW-1:0];
        unused_hi = rdata[DW-1:RW];
    end

endmodule

// File: rtl/lda_unit.sv
module lda_unit
    import lda_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int RW = REG_W,
    parameter int IW = IDX_W,
    parameter int PW = MID_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    op_kind,
    input  logic [PW-1:0] op_imm,
    input  logic [IW-1:0] op_rd,
    input  logic          op_slot,
    input  logic [AW-1:0] sp,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          rf_we,
    output logic [IW-1:0] rf_idx,
    output logic [RW-1:0] rf_wdata,
    output logic          misalign_irq
);

    op_kind_e      kind;
    pfx_acc_t      acc;
    logic [AW-1:0] waddr;
    logic          mis;
    logic          issue;

    assign kind  = op_kind_e'(op_kind);
    assign issue = (kind == OPK_LOAD);

    lda_prefix_acc #(.IMM_W(PW)) u_acc (
        .clk (clk),
        .rst (rst),
        .kind(kind),
        .imm (op_imm),
        .acc (acc)
    );

    lda_addr_gen #(.AW(AW), .AL(ALIGN_W)) u_agen (
        .acc       (acc),
        .in_slot   (op_slot),
        .low       (op_imm[LOW_W-1:0]),
        .base      (sp),
        .word_addr (waddr),
        .misaligned(mis)
    );

    lda_access_seq #(.AW(AW), .DW(DW), .RW(RW), .IW(IW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue),
        .addr     (waddr),
        .bad_align(mis),
        .dest     (op_rd),
        .rdata    (mem_rdata),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_addr),
        .irq      (misalign_irq),
        .wr_en    (rf_we),
        .wr_idx   (rf_idx),
        .wr_data  (rf_wdata)
    );

endmodule

// File: rtl/lda_unit_chk.sv
module lda_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  op_kind,
    input logic [2:0]  op_rd,
    input logic        mem_rd_en,
    input logic [23:0] mem_addr,
    input logic        rf_we,
    input logic [2:0]  rf_idx,
    input logic        misalign_irq
);

    assert_irq_with_read_R6: assert property (@(posedge clk) disable iff (rst)
        misalign_irq |-> mem_rd_en);

    assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_addr[1:0] == 2'b00));

    assert_read_after_load_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> ($past(op_kind) == 2'd2));

    assert_write_follows_read_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> rf_we);

    assert_write_index_R5: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> ($past(op_kind, 2) == 2'd2 && rf_idx == $past(op_rd, 2)));

endmodule

bind lda_unit lda_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_kind     (op_kind),
    .op_rd       (op_rd),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .rf_we       (rf_we),
    .rf_idx      (rf_idx),
    .misalign_irq(misalign_irq)
);

// File: tb/tb_lda_unit.sv
module tb_lda_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_kind = 2'd0;
    logic [12:0] op_imm = '0;
    logic [2:0]  op_rd = '0;
    logic        op_slot = 1'b0;
    logic [23:0] sp = '0;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        rf_we;
    logic [2:0]  rf_idx;
    logic [23:0] rf_wdata;
    logic        misalign_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lda_unit dut (.*);

    function automatic logic [31:0] mem_word(input logic [23:0] a);
        return {8'hC3, a ^ 24'h5A5A5A};
    endfunction

    always @(posedge clk)
        mem_rdata <= mem_rd_en ? mem_word(mem_addr) : 32'hDEADBEEF;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // fields: sp, nprefix, slot, p0, p1, p2, imm7, rd
    localparam int NV = 8;
    localparam logic [75:0] VEC [NV] = '{
        {24'h001000, 2'd0, 1'b0, 13'h0000, 13'h0000, 13'h0000, 7'h04, 3'd0},
        {24'h002000, 2'd1, 1'b0, 13'h0001, 13'h0000, 13'h0000, 7'h04, 3'd3},
        {24'h100000, 2'd2, 1'b0, 13'h000A, 13'h1FFF, 13'h0000, 7'h7C, 3'd5},
        {24'h003001, 2'd0, 1'b0, 13'h0000, 13'h0000, 13'h0000, 7'h02, 3'd7},
        {24'h004000, 2'd1, 1'b1, 13'h0FFF, 13'h0000, 13'h0000, 7'h10, 3'd1},
        {24'h000000, 2'd3, 1'b0, 13'h0003, 13'h0005, 13'h0002, 7'h00, 3'd2},
        {24'hFFFFF0, 2'd0, 1'b0, 13'h0000, 13'h0000, 13'h0000, 7'h14, 3'd4},
        {24'hF00000, 2'd2, 1'b0, 13'h0003, 13'h0000, 13'h0000, 7'h01, 3'd6}
    };

    task automatic send_pfx(input logic [12:0] v);
        @(negedge clk);
        op_kind = 2'd1; op_imm = v; op_slot = 1'b0;
    endtask

    task automatic do_load(input logic [23:0] s, input logic slot, input logic [6:0] i7,
                           input logic [2:0] rd, input logic [23:0] ea, input string tag);
        logic [23:0] wa;
        wa = {ea[23:2], 2'b00};
        @(negedge clk);
        op_kind = 2'd2; op_imm = {6'b0, i7}; op_rd = rd; op_slot = slot; sp = s;
        @(negedge clk);
        op_kind = 2'd0; op_slot = 1'b0;
        chk({tag, " R8 read strobe"}, {31'b0, mem_rd_en}, 32'd1);
        chk({tag, " address R6"}, {8'b0, mem_addr}, {8'b0, wa});
        chk({tag, " R6 irq"}, {31'b0, misalign_irq}, {31'b0, |ea[1:0]});
        @(negedge clk);
        chk({tag, " R8 write enable"}, {31'b0, rf_we}, 32'd1);
        chk({tag, " R8 strobe single"}, {31'b0, mem_rd_en}, 32'd0);
        chk({tag, " R6 irq pulse ends"}, {31'b0, misalign_irq}, 32'd0);
        chk({tag, " R5 index"}, {29'b0, rf_idx}, {29'b0, rd});
        chk({tag, " R4 data"}, {8'b0, rf_wdata}, {8'b0, wa ^ 24'h5A5A5A});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 rd_en in reset", {31'b0, mem_rd_en}, 32'd0);
        chk("R12 we in reset", {31'b0, rf_we}, 32'd0);
        chk("R12 irq in reset", {31'b0, misalign_irq}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 rd_en after reset", {31'b0, mem_rd_en}, 32'd0);

        // table: R1 R2 R3 R7 R9 R11
        for (int v = 0; v < NV; v++) begin
            logic [23:0] s, d;
            logic [1:0]  np;
            logic        sl;
            logic [12:0] p0, p1, p2, older, newer;
            logic [6:0]  i7;
            logic [2:0]  rd;
            {s, np, sl, p0, p1, p2, i7, rd} = VEC[v];
            if (np > 0) send_pfx(p0);
            if (np > 1) send_pfx(p1);
            if (np > 2) send_pfx(p2);
            newer = (np == 1) ? p0 : (np == 2) ? p1 : p2;
            older = (np == 2) ? p0 : p1;
            d = {17'b0, i7};
            if (!sl && np != 0) d[19:7] = newer;
            if (!sl && np >= 2) d[23:20] = older[3:0];
            do_load(s, sl, i7, rd, s + d, $sformatf("vec%0d R1/R2/R3/R7/R9/R11", v));
        end

        // R10: other instruction drops prefix
        send_pfx(13'h1FFF);
        @(negedge clk); op_kind = 2'd3;
        do_load(24'h001000, 1'b0, 7'h08, 3'd1, 24'h001008, "R10 other clears");

        // R10: reset drops prefix
        send_pfx(13'h0ABC);
        @(negedge clk); op_kind = 2'd0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_load(24'h002000, 1'b0, 7'h00, 3'd2, 24'h002000, "R10 reset clears");

        // R2: idle keeps prefix
        send_pfx(13'h0001);
        @(negedge clk); op_kind = 2'd0;
        do_load(24'h000000, 1'b0, 7'h00, 3'd3, 24'h000080, "R2 idle keeps");
        // R10: consumed by previous load
        do_load(24'h000000, 1'b0, 7'h00, 3'd4, 24'h000000, "R10 load consumes");

        // R7: delay-slot load also consumes the pending prefix
        send_pfx(13'h0004);
        do_load(24'h000100, 1'b1, 7'h06, 3'd5, 24'h000106, "R7 slot ignores");
        do_load(24'h000100, 1'b0, 7'h00, 3'd6, 24'h000100, "R10 after slot");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule